// File: doc/BRIEF.md
# Conversion Result Holding Register with Torn-Read Lock

This block keeps the most recent 10-bit result produced by a converter sequencer and offers it to a byte-wide bus as two bytes, a low byte and a high byte. The sequencer hands over a new value with a one-cycle completion strobe. Software reads the two bytes through two read strobes, and an alignment select chooses between a right-adjusted and a left-adjusted layout.

Two bytes cannot be read at the same instant, so a result may change between the two reads. To stop that, a read of the low byte freezes the stored result until the high byte is read. A completion that arrives during that window is thrown away. The block still issues its completion pulse for it and records the loss in a sticky status bit, which software clears by writing a one.

Top module: `adc_result_latch`

## Requirements
- R1: After reset both bytes read zero, the lock is released, the lost-result bit is clear and no completion pulse is present.
- R2: While unlocked, a completion strobe stores the 10-bit value, and the formatted bytes show it from the following cycle.
- R3: With align_left low, hi_byte is {6'b0, result[9:8]} and lo_byte is result[7:0].
- R4: With align_left high, hi_byte is result[9:2] and lo_byte is {result[1:0], 6'b0}.
- R5: Changing align_left re-formats the stored value in the same cycle, with no new conversion.
- R6: A low-byte read sets the lock. A completion in that same cycle, or in any later cycle while the lock holds, leaves both bytes unchanged.
- R7: A high-byte read without a low-byte read releases the lock from the next cycle. A completion in the same cycle as that high-byte read is stored.
- R8: done_pulse is high for exactly the cycle after each completion strobe, whether or not the value was kept.
- R9: A discarded completion sets lost_flag. A lost_clr pulse clears it, but a discard in the same cycle as the clear takes priority and keeps it set.
- R10: A low-byte read and a high-byte read in the same cycle leave the lock set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle completion strobe from the sequencer |
| conv_value | input | 10 | Converted value, valid together with conv_done |
| rd_lo | input | 1 | Bus read strobe for the low byte |
| rd_hi | input | 1 | Bus read strobe for the high byte |
| align_left | input | 1 | 1 selects the left-adjusted layout, 0 the right-adjusted one |
| lost_clr | input | 1 | Write-one strobe that clears lost_flag |
| lo_byte | output | 8 | Formatted low byte |
| hi_byte | output | 8 | Formatted high byte |
| locked | output | 1 | Lock state |
| done_pulse | output | 1 | Completion report, one cycle after conv_done |
| lost_flag | output | 1 | Sticky indication that a result was discarded |

## Verification
The hardest cases to reach are the ones where several strobes land in the same clock cycle. These are a completion together with the low-byte read that closes the window, a completion together with the high-byte read that opens it, and a discard together with the write-one clear. Directed steps place each of these collisions on a chosen edge. A long stretch of random strobes then follows, with a reference model that tracks the lock, the stored value and the sticky bit and compares every output on every cycle.

// File: rtl/adc_rl_pkg.sv
package adc_rl_pkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int SPILL  = RES_W - BYTE_W;   // bits that do not fit one byte
  localparam int PAD    = BYTE_W - SPILL;   // zero fill in the partial byte

  typedef logic [RES_W-1:0]  res_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t hi;
    byte_t lo;
  } pair_t;

  // Right-adjusted: full low byte, the spill bits at the bottom of the high byte.
  function automatic pair_t pack_right(input res_t r);
    pair_t p;
    p = '0;
    for (int i = 0; i < BYTE_W; i++) p.lo[i] = r[i];
    for (int i = 0; i < SPILL; i++)  p.hi[i] = r[BYTE_W+i];
    return p;
  endfunction

  // Left-adjusted: the top bits fill the high byte, the rest sit at the top of the low byte.
  function automatic pair_t pack_left(input res_t r);
    pair_t p;
    p = '0;
    for (int i = 0; i < BYTE_W; i++) p.hi[i] = r[SPILL+i];
    for (int i = 0; i < SPILL; i++)  p.lo[PAD+i] = r[i];
    return p;
  endfunction
endpackage

// File: rtl/adc_rl_lock.sv
module adc_rl_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_lo,
  input  logic rd_hi,
  input  logic conv_done,
  output logic locked,
  output logic write_ok,
  output logic drop_evt
);
  logic lock_q;
  logic blocked;

  // A low read closes the window at once. A high read lets a same-cycle write through.
  assign blocked  = rd_lo | (lock_q & ~rd_hi);
  assign write_ok = conv_done & ~blocked;
  assign drop_evt = conv_done & blocked;
  assign locked   = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (rd_lo) lock_q <= 1'b1;
    else if (rd_hi) lock_q <= 1'b0;
  end
endmodule

// File: rtl/adc_rl_store.sv
module adc_rl_store
  import adc_rl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic write_ok,
  input  res_t conv_value,
  output res_t stored
);
  res_t res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (write_ok) res_q <= conv_value;
  end

  assign stored = res_q;
endmodule

// File: rtl/adc_rl_status.sv
module adc_rl_status (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_done,
  input  logic drop_evt,
  input  logic lost_clr,
  output logic done_pulse,
  output logic lost_flag
);
  logic done_q, lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      done_q <= conv_done;
      if (drop_evt)      lost_q <= 1'b1;
      else if (lost_clr) lost_q <= 1'b0;
    end
  end

  assign done_pulse = done_q;
  assign lost_flag  = lost_q;
endmodule

// File: rtl/adc_rl_format.sv
module adc_rl_format
  import adc_rl_pkg::*;
(
  input  res_t  stored,
  input  logic  align_left,
  output byte_t lo_byte,
  output byte_t hi_byte
);
  pair_t p;

  always_comb begin
    if (align_left) p = pack_left(stored);
    else            p = pack_right(stored);
  end

  assign lo_byte = p.lo;
  assign hi_byte = p.hi;
endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
  import adc_rl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_done,
  input  logic [9:0] conv_value,
  input  logic       rd_lo,
  input  logic       rd_hi,
  input  logic       align_left,
  input  logic       lost_clr,
  output logic [7:0] lo_byte,
  output logic [7:0] hi_byte,
  output logic       locked,
  output logic       done_pulse,
  output logic       lost_flag
);
  // Named internal events, reachable by the bound checker.
  logic write_w;
  logic drop_w;
  res_t stored_w;

  adc_rl_lock u_lock (
    .clk(clk), .rst_n(rst_n), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .conv_done(conv_done), .locked(locked), .write_ok(write_w), .drop_evt(drop_w)
  );

  adc_rl_store u_store (
    .clk(clk), .rst_n(rst_n), .write_ok(write_w),
    .conv_value(conv_value), .stored(stored_w)
  );

  adc_rl_status u_status (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .drop_evt(drop_w),
    .lost_clr(lost_clr), .done_pulse(done_pulse), .lost_flag(lost_flag)
  );

  adc_rl_format u_fmt (
    .stored(stored_w), .align_left(align_left),
    .lo_byte(lo_byte), .hi_byte(hi_byte)
  );
endmodule

// File: rtl/adc_rl_chk.sv
module adc_rl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_done,
  input logic [9:0] conv_value,
  input logic       rd_lo,
  input logic       rd_hi,
  input logic       lost_clr,
  input logic       locked,
  input logic       done_pulse,
  input logic       lost_flag,
  input logic       drop_w,
  input logic [9:0] stored_w
);
  a_r2_store_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !rd_lo && (!locked || rd_hi)) |=> (stored_w == $past(conv_value)));

  a_r6_hold_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && (rd_lo || (locked && !rd_hi))) |=> $stable(stored_w));

  a_r6_low_read_locks: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> locked);

  a_r7_high_read_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !rd_lo) |=> !locked);

  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_pulse);

  a_r8_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !done_pulse);

  a_r9_lost_set: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> lost_flag);

  a_r9_lost_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_clr && !drop_w) |=> !lost_flag);
endmodule

bind adc_result_latch adc_rl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
  .rd_lo(rd_lo), .rd_hi(rd_hi), .lost_clr(lost_clr), .locked(locked),
  .done_pulse(done_pulse), .lost_flag(lost_flag), .drop_w(drop_w),
  .stored_w(stored_w)
);

// File: tb/sim_adc_result_latch.sv
`timescale 1ns/1ps
module sim_adc_result_latch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_value = '0;
  logic       rd_lo = 1'b0, rd_hi = 1'b0, align_left = 1'b0, lost_clr = 1'b0;
  logic [7:0] lo_byte, hi_byte;
  logic       locked, done_pulse, lost_flag;

  int checks = 0;
  int errors = 0;

  // Reference state
  int  m_val  = 0;
  bit  m_lock = 0, m_done = 0, m_lost = 0;

  always #2.5 clk = ~clk;

  adc_result_latch u0 (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_value(conv_value),
    .rd_lo(rd_lo), .rd_hi(rd_hi), .align_left(align_left), .lost_clr(lost_clr),
    .lo_byte(lo_byte), .hi_byte(hi_byte), .locked(locked),
    .done_pulse(done_pulse), .lost_flag(lost_flag)
  );

  // Behavioural model, advanced at each edge from the inputs held stable there.
  always @(posedge clk) begin
    if (rst_n) begin
      bit keep;
      keep   = conv_done && !rd_lo && (!m_lock || rd_hi);
      m_done = conv_done;
      if (conv_done && !keep) m_lost = 1;
      else if (lost_clr)      m_lost = 0;
      if (keep) m_val = conv_value;
      if (rd_lo)      m_lock = 1;
      else if (rd_hi) m_lock = 0;
    end
  end

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Comparison on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      int e_hi, e_lo;
      if (align_left) begin
        e_hi = m_val / 4;           // R4
        e_lo = (m_val % 4) * 64;
      end else begin
        e_hi = m_val / 256;         // R3
        e_lo = m_val % 256;
      end
      expect_eq(align_left ? "R4" : "R3", "hi_byte", hi_byte, e_hi);
      expect_eq(align_left ? "R4" : "R3", "lo_byte", lo_byte, e_lo);
      expect_eq("R6/R7/R10", "locked", locked, m_lock);
      expect_eq("R8", "done_pulse", done_pulse, m_done);
      expect_eq("R9", "lost_flag", lost_flag, m_lost);
    end
  end

  task automatic drive(input bit d, input int v, input bit lo, input bit hi, input bit clr);
    @(negedge clk); #1;
    conv_done = d; conv_value = v[9:0]; rd_lo = lo; rd_hi = hi; lost_clr = clr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        #5_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    expect_eq("R1", "lo_byte", lo_byte, 0);
    expect_eq("R1", "hi_byte", hi_byte, 0);
    expect_eq("R1", "locked", locked, 0);
    expect_eq("R1", "lost_flag", lost_flag, 0);
    expect_eq("R1", "done_pulse", done_pulse, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3: store while unlocked, right layout
    drive(1, 'h3A5, 0, 0, 0); idle(1);
    expect_eq("R2", "hi_byte", hi_byte, 'h03);
    expect_eq("R2", "lo_byte", lo_byte, 'hA5);
    // R5/R4: flip alignment without a conversion
    @(negedge clk); #1 align_left = 1'b1; #1;
    expect_eq("R5", "hi_byte", hi_byte, 'hE9);
    expect_eq("R5", "lo_byte", lo_byte, 'h40);
    // R6: low read locks; completion while locked is dropped and reported
    drive(0, 0, 1, 0, 0);
    drive(1, 'h155, 0, 0, 0); idle(1);
    expect_eq("R6", "hi_byte kept", hi_byte, 'hE9);
    expect_eq("R9", "lost_flag set", lost_flag, 1);
    // R7: completion together with the high read is kept
    drive(1, 'h2AA, 0, 1, 0); idle(1);
    expect_eq("R7", "hi_byte new", hi_byte, 'hAA);
    expect_eq("R7", "locked", locked, 0);
    // R9: clear
    drive(0, 0, 0, 0, 1); idle(1);
    expect_eq("R9", "lost cleared", lost_flag, 0);
    // R6: completion in the same cycle as the low read is blocked
    @(negedge clk); #1 align_left = 1'b0;
    drive(1, 'h0FF, 1, 0, 0); idle(1);
    expect_eq("R6", "same-cycle block lo", lo_byte, 'hAA);
    // R9: discard wins over a same-cycle clear
    drive(1, 'h001, 0, 0, 1); idle(1);
    expect_eq("R9", "set beats clear", lost_flag, 1);
    // R10: both reads together keep the lock
    drive(0, 0, 1, 1, 0); idle(1);
    expect_eq("R10", "locked", locked, 1);
    drive(0, 0, 0, 1, 1); idle(2);

    // Random collisions, compared cycle by cycle by the model
    for (int i = 0; i < 2000; i++) begin
      drive($urandom_range(0, 2) == 0, $urandom, $urandom_range(0, 5) == 0,
            $urandom_range(0, 4) == 0, $urandom_range(0, 7) == 0);
      if ($urandom_range(0, 15) == 0) align_left = ~align_left;
    end
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule